// File: doc/BRIEF.md
# Conditional Instruction Decoder

This block turns one 16-bit instruction word into the control signals for a simple single-issue datapath in the same cycle. It pulls out the destination and two source register codes, builds the immediate operand, picks the ALU operation and the write-back source, and drives the register write, flag write and memory read/write strobes. It also says whether the program counter must load the written value or simply step by one.

Every instruction carries a condition bit (bit 11). When that bit is set and the zero flag from the flag register is clear, the instruction is cancelled. It then changes no register, no memory word and no flag, and the program counter steps as usual. The register file, ALU and memory sit outside the block. The datapath uses source port A as the memory address and source port B as the store data. For the high-byte insert, port A carries the destination register, so the datapath can keep that register's low byte.

Top module: `qd_decode`

## Requirements
- R1: Register codes come from fixed fields: `dst_sel` = instr[10:8], and for register-format instructions `srca_sel` = instr[6:4]. For ALU instructions `srcb_sel` = instr[2:0]. The opcode is instr[15:12] and the 8-bit immediate is instr[7:0].
- R2: When instr[11]=1 and `zflag`=0, the instruction is cancelled: `exec`, `reg_we`, `mem_rd`, `mem_wr`, `flag_we` and `pc_load` are all 0.
- R3: When instr[11]=0 the instruction executes whatever the value of `zflag`. When instr[11]=1 and `zflag`=1 it also executes, and `exec` is 1.
- R4: Opcode 0000 (load low) gives `wb_src`=1, `imm_val` = imm8 zero-extended, and `reg_we`=1.
- R5: Opcode 0001 (insert high byte) gives `wb_src`=2, `imm_val` = imm8<<8, `srca_sel` = the destination code, and `reg_we`=1.
- R6: Opcode 0100 (store) gives `mem_wr`=1, `srca_sel`=ra as the address, `srcb_sel`=rd as the data, and `reg_we`=0 and `mem_rd`=0.
- R7: Opcode 0101 (load) gives `mem_rd`=1, `wb_src`=3, `srca_sel`=ra and `reg_we`=1.
- R8: Opcodes 1000, 1001, 1010 and 1011 give `alu_op` 0 (add), 1 (subtract), 2 (AND) and 3 (OR). They also give `wb_src`=0, `flag_we`=1 and `reg_we`=1.
- R9: `flag_we` is never 1 for an opcode outside 1000 to 1011.
- R10: `pc_load` is 1 exactly when the instruction executes, writes a register, and has destination code 111. A store to code 111 leaves `pc_load`=0.
- R11: Opcodes 0010, 0011, 0110, 0111 and 1100 to 1111 assert no write enable, no memory strobe and no `pc_load`.
- R12: Bits 7 and 3 of a register-format instruction have no effect on any output.
- R13: A register write to destination code 000 gives `reg_we`=0. The flag write of an ALU instruction to code 000 is still made (a compare).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Fetched instruction word |
| zflag | input | 1 | Zero flag, bit 0 of the flag register |
| dst_sel | output | 3 | Destination register code |
| srca_sel | output | 3 | Source A register code (address, or destination for high insert) |
| srcb_sel | output | 3 | Source B register code (operand, or store data) |
| imm_val | output | 16 | Immediate positioned for the write-back |
| alu_op | output | 2 | 0 add, 1 subtract, 2 AND, 3 OR |
| wb_src | output | 2 | 0 ALU, 1 low immediate, 2 high-byte insert, 3 memory |
| reg_we | output | 1 | Register file write enable |
| flag_we | output | 1 | Flag register write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_load | output | 1 | Program counter takes the written value instead of pc+1 |
| exec | output | 1 | Instruction is not cancelled |

## Verification
The hardest case to reach is the interplay between cancellation and the program-counter decision. A jump written as a load-low to code 111 must lose `pc_load` only when it is cancelled, while a store naming code 111 must never raise it. The stimulus reaches this by sending the same jump word with `zflag` low and then high, and by sending a store whose data register code is 111. It also sends ALU words with only the reserved bits flipped and compares every output against the unflipped word.

// File: rtl/qd_pkg.sv
// Shared encodings for the conditional instruction decoder.
package qd_pkg;
    localparam logic [3:0] OPC_MOVL = 4'h0;
    localparam logic [3:0] OPC_SETH = 4'h1;
    localparam logic [3:0] OPC_STR  = 4'h4;
    localparam logic [3:0] OPC_LDR  = 4'h5;
    localparam logic [3:0] OPC_ADD  = 4'h8;
    localparam logic [3:0] OPC_SUB  = 4'h9;
    localparam logic [3:0] OPC_AND  = 4'hA;
    localparam logic [3:0] OPC_ORR  = 4'hB;

    typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_AND = 2'd2, ALU_OR = 2'd3} alu_op_e;
    typedef enum logic [1:0] {WB_ALU = 2'd0, WB_IMM_LO = 2'd1, WB_IMM_HI = 2'd2, WB_MEM = 2'd3} wb_src_e;

    typedef struct packed {
        logic reg_we;
        logic flag_we;
        logic mem_rd;
        logic mem_wr;
    } side_fx_t;
endpackage

// File: rtl/qd_fields.sv
// Field splitter: cuts an instruction word into opcode, condition bit,
// register codes and immediate. Assumes the fixed two-format layout; the
// reserved bits between register fields are not brought out.
module qd_fields #(
    parameter int INSTR_W = 16,
    parameter int RSEL_W  = 3,
    parameter int IMM_W   = 8,
    localparam int OP_W   = INSTR_W - 1 - RSEL_W - IMM_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [OP_W-1:0]    opcode,
    output logic               cond,
    output logic [RSEL_W-1:0]  rd,
    output logic [RSEL_W-1:0]  ra,
    output logic [RSEL_W-1:0]  rb,
    output logic [IMM_W-1:0]   imm
);
    localparam int COND_BIT = INSTR_W - OP_W - 1;
    localparam int RD_LSB   = COND_BIT - RSEL_W;
    localparam int RA_LSB   = RSEL_W + 1;

    // Slice the fixed fields out of the word.
    always_comb begin
        opcode = instr[INSTR_W-1 -: OP_W];
        cond   = instr[COND_BIT];
        rd     = instr[RD_LSB +: RSEL_W];
        ra     = instr[RA_LSB +: RSEL_W];
        rb     = instr[0 +: RSEL_W];
        imm    = instr[0 +: IMM_W];
    end
endmodule

// File: rtl/qd_opclass.sv
// Opcode classifier: produces the unconditional control set for an opcode.
// Assumes undefined opcodes behave as no-operations; the condition is
// applied later by the gate stage.
module qd_opclass #(
    parameter int INSTR_W = 16,
    parameter int RSEL_W  = 3,
    parameter int IMM_W   = 8,
    localparam int OP_W   = INSTR_W - 1 - RSEL_W - IMM_W
) (
    input  logic [OP_W-1:0]    opcode,
    input  logic [RSEL_W-1:0]  rd,
    input  logic [RSEL_W-1:0]  ra,
    input  logic [RSEL_W-1:0]  rb,
    input  logic [IMM_W-1:0]   imm,
    output logic [RSEL_W-1:0]  srca,
    output logic [RSEL_W-1:0]  srcb,
    output logic [INSTR_W-1:0] imm_out,
    output qd_pkg::alu_op_e    alu_op,
    output qd_pkg::wb_src_e    wb_src,
    output qd_pkg::side_fx_t   fx
);
    import qd_pkg::*;

    localparam int PAD_W = INSTR_W - IMM_W;

    // Map each opcode to operand routing, immediate and raw side effects.
    always_comb begin
        srca    = ra;
        srcb    = rb;
        imm_out = '0;
        alu_op  = ALU_ADD;
        wb_src  = WB_ALU;
        fx      = '0;
        unique case (opcode)
            OPC_MOVL: begin
                imm_out   = {{PAD_W{1'b0}}, imm};
                wb_src    = WB_IMM_LO;
                fx.reg_we = 1'b1;
            end
            OPC_SETH: begin
                imm_out   = {imm, {PAD_W{1'b0}}};
                srca      = rd;
                wb_src    = WB_IMM_HI;
                fx.reg_we = 1'b1;
            end
            OPC_STR: begin
                srcb      = rd;
                fx.mem_wr = 1'b1;
            end
            OPC_LDR: begin
                wb_src    = WB_MEM;
                fx.reg_we = 1'b1;
                fx.mem_rd = 1'b1;
            end
            OPC_ADD, OPC_SUB, OPC_AND, OPC_ORR: begin
                alu_op     = alu_op_e'(opcode[1:0]);
                fx.reg_we  = 1'b1;
                fx.flag_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qd_cond_gate.sv
// Condition gate: cancels all side effects of a conditional instruction
// whose zero flag is clear, drops writes to the zero register and decides
// whether the program counter loads the written value.
module qd_cond_gate #(
    parameter int RSEL_W = 3,
    localparam logic [RSEL_W-1:0] ZERO_CODE = '0,
    localparam logic [RSEL_W-1:0] PC_CODE   = '1
) (
    input  logic              cond,
    input  logic              zflag,
    input  logic [RSEL_W-1:0] rd,
    input  qd_pkg::side_fx_t  fx_raw,
    output qd_pkg::side_fx_t  fx_out,
    output logic              pc_load,
    output logic              exec
);
    logic run;

    // Execute unless conditional and the zero flag is clear.
    always_comb run = !cond || zflag;

    // Gate every side effect and resolve the pc source.
    always_comb begin
        fx_out         = run ? fx_raw : '0;
        fx_out.reg_we  = run && fx_raw.reg_we && (rd != ZERO_CODE);
        pc_load        = run && fx_raw.reg_we && (rd == PC_CODE);
        exec           = run;
    end
endmodule

// File: rtl/qd_decode.sv
// Top of the conditional instruction decoder. Purely combinational: one
// instruction word in, one control set out in the same cycle. Assumes the
// datapath uses source A as memory address and B as store data.
module qd_decode #(
    parameter int INSTR_W = 16,
    parameter int RSEL_W  = 3,
    parameter int IMM_W   = 8
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               zflag,
    output logic [RSEL_W-1:0]  dst_sel,
    output logic [RSEL_W-1:0]  srca_sel,
    output logic [RSEL_W-1:0]  srcb_sel,
    output logic [INSTR_W-1:0] imm_val,
    output logic [1:0]         alu_op,
    output logic [1:0]         wb_src,
    output logic               reg_we,
    output logic               flag_we,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               pc_load,
    output logic               exec
);
    import qd_pkg::*;

    localparam int OP_W = INSTR_W - 1 - RSEL_W - IMM_W;

    logic [OP_W-1:0]   opcode;
    logic              cond;
    logic [RSEL_W-1:0] rd, ra, rb;
    logic [IMM_W-1:0]  imm;
    alu_op_e           alu_op_i;
    wb_src_e           wb_src_i;
    side_fx_t          fx_raw, fx_gated;

    qd_fields #(.INSTR_W(INSTR_W), .RSEL_W(RSEL_W), .IMM_W(IMM_W)) u_fields (
        .instr(instr), .opcode(opcode), .cond(cond),
        .rd(rd), .ra(ra), .rb(rb), .imm(imm)
    );

    qd_opclass #(.INSTR_W(INSTR_W), .RSEL_W(RSEL_W), .IMM_W(IMM_W)) u_class (
        .opcode(opcode), .rd(rd), .ra(ra), .rb(rb), .imm(imm),
        .srca(srca_sel), .srcb(srcb_sel), .imm_out(imm_val),
        .alu_op(alu_op_i), .wb_src(wb_src_i), .fx(fx_raw)
    );

    qd_cond_gate #(.RSEL_W(RSEL_W)) u_gate (
        .cond(cond), .zflag(zflag), .rd(rd), .fx_raw(fx_raw),
        .fx_out(fx_gated), .pc_load(pc_load), .exec(exec)
    );

    // Drive the flat output ports from the internal records.
    always_comb begin
        dst_sel = rd;
        alu_op  = alu_op_i;
        wb_src  = wb_src_i;
        reg_we  = fx_gated.reg_we;
        flag_we = fx_gated.flag_we;
        mem_rd  = fx_gated.mem_rd;
        mem_wr  = fx_gated.mem_wr;
    end
endmodule

// File: rtl/qd_decode_chk.sv
// Checker for qd_decode: relates the instruction word at the ports to the
// control outputs. Combinational block, so immediate assertions are used.
module qd_decode_chk #(
    parameter int INSTR_W = 16,
    parameter int RSEL_W  = 3
) (
    input logic [INSTR_W-1:0] instr,
    input logic               zflag,
    input logic [RSEL_W-1:0]  dst_sel,
    input logic               reg_we,
    input logic               flag_we,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               pc_load,
    input logic               exec
);
    logic [3:0] op;
    logic       cancel;

    // Observe the opcode and the cancel condition at the ports.
    always_comb begin
        op     = instr[INSTR_W-1 -: 4];
        cancel = instr[INSTR_W-5] && !zflag;
    end

    // Check the documented relations between inputs and controls.
    always_comb begin
        a_r2_cancel_quiet: assert (!cancel || !(reg_we || flag_we || mem_rd || mem_wr || pc_load || exec));
        a_r3_exec_when_free: assert (cancel || exec);
        a_r9_flag_alu_only: assert (!flag_we || op[3:2] == 2'b10);
        a_r6_store_no_regwrite: assert (!mem_wr || (!reg_we && !mem_rd && !pc_load));
        a_r10_pcload_dest: assert (!pc_load || (dst_sel == '1 && exec && !mem_wr));
        a_r13_zero_dest: assert (!reg_we || dst_sel != '0);
        a_r11_undef_idle: assert (!(op == 4'h2 || op == 4'h3 || op == 4'h6 || op == 4'h7 || op[3:2] == 2'b11)
                                  || !(reg_we || flag_we || mem_rd || mem_wr || pc_load));
    end
endmodule

bind qd_decode qd_decode_chk #(.INSTR_W(INSTR_W), .RSEL_W(RSEL_W)) u_chk (
    .instr(instr), .zflag(zflag), .dst_sel(dst_sel), .reg_we(reg_we),
    .flag_we(flag_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_load(pc_load), .exec(exec)
);

// File: tb/sim_qd_decode.sv
module sim_qd_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        zflag = 1'b0;
    logic [2:0]  dst_sel, srca_sel, srcb_sel;
    logic [15:0] imm_val;
    logic [1:0]  alu_op, wb_src;
    logic        reg_we, flag_we, mem_rd, mem_wr, pc_load, exec;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    qd_decode u0 (
        .instr(instr), .zflag(zflag), .dst_sel(dst_sel), .srca_sel(srca_sel),
        .srcb_sel(srcb_sel), .imm_val(imm_val), .alu_op(alu_op), .wb_src(wb_src),
        .reg_we(reg_we), .flag_we(flag_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .pc_load(pc_load), .exec(exec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply a word after the falling edge, sample before the next rising edge.
    task automatic apply(input logic [15:0] w, input logic z);
        @(negedge clk);
        instr = w;
        zflag = z;
        #2;
    endtask

    function automatic logic [7:0] fx();
        return {reg_we, flag_we, mem_rd, mem_wr, pc_load, exec, 2'b00};
    endfunction

    task automatic t_reset_nop();
        apply(16'h0000, 1'b0);
        chk("R13 nop reg_we", reg_we, 0);
        chk("R10 nop pc_load", pc_load, 0);
        chk("R3 nop exec", exec, 1);
    endtask

    task automatic t_movl();
        apply(16'h03A5, 1'b0);
        chk("R4 imm", imm_val, 16'h00A5);
        chk("R4 wb", wb_src, 1);
        chk("R4 we", reg_we, 1);
        chk("R1 dst", dst_sel, 3);
    endtask

    task automatic t_seth();
        apply(16'h127C, 1'b0);
        chk("R5 imm", imm_val, 16'h7C00);
        chk("R5 wb", wb_src, 2);
        chk("R5 srca", srca_sel, 2);
        chk("R5 we", reg_we, 1);
    endtask

    task automatic t_str();
        apply(16'h4410, 1'b0);
        chk("R6 fx", fx(), {8'b00010100});
        chk("R6 srca", srca_sel, 1);
        chk("R6 srcb", srcb_sel, 4);
    endtask

    task automatic t_ldr();
        apply(16'h5130, 1'b0);
        chk("R7 fx", fx(), {8'b10100100});
        chk("R7 wb", wb_src, 3);
        chk("R7 srca", srca_sel, 3);
        chk("R1 dst", dst_sel, 1);
    endtask

    task automatic t_alu();
        for (int k = 0; k < 4; k++) begin
            apply({4'h8 | 4'(k), 1'b0, 3'd2, 1'b0, 3'd3, 1'b0, 3'd4}, 1'b0);
            chk("R8 op", alu_op, k);
            chk("R8 fx", fx(), {8'b11000100});
            chk("R8 wb", wb_src, 0);
            chk("R1 srca", srca_sel, 3);
            chk("R1 srcb", srcb_sel, 4);
        end
    endtask

    task automatic t_cond();
        apply(16'h8A34, 1'b0);
        chk("R2 add cancelled", fx(), 0);
        apply(16'h5930, 1'b0);
        chk("R2 ldr cancelled", fx(), 0);
        apply(16'h4C10, 1'b0);
        chk("R2 str cancelled", fx(), 0);
        apply(16'h8A34, 1'b1);
        chk("R3 add runs z set", fx(), {8'b11000100});
        apply(16'h0234, 1'b1);
        chk("R3 movl uncond zflag1", fx(), {8'b10000100});
    endtask

    task automatic t_pc();
        apply(16'h0720, 1'b0);
        chk("R10 jump", pc_load, 1);
        apply(16'h0F20, 1'b0);
        chk("R10 jump cancelled", pc_load, 0);
        apply(16'h0F20, 1'b1);
        chk("R10 jump taken", pc_load, 1);
        apply(16'h4710, 1'b0);
        chk("R10 store rd7", pc_load, 0);
        chk("R6 store rd7 data", srcb_sel, 7);
    endtask

    task automatic t_undef();
        logic [3:0] ops [8] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hC, 4'hD, 4'hE, 4'hF};
        for (int k = 0; k < 8; k++) begin
            apply({ops[k], 1'b0, 3'd7, 8'h12}, 1'b1);
            chk("R11 undef fx", fx(), {8'b00000100});
            chk("R9 undef flag", flag_we, 0);
        end
    endtask

    task automatic t_reserved();
        logic [31:0] base_a, base_b;
        apply(16'h8A34, 1'b1);
        base_a = {dst_sel, srca_sel, srcb_sel, alu_op, wb_src, fx(), imm_val[6:0]};
        apply(16'h8A34 | 16'h0088, 1'b1);
        base_b = {dst_sel, srca_sel, srcb_sel, alu_op, wb_src, fx(), imm_val[6:0]};
        chk("R12 reserved add", base_b, base_a);
        apply(16'h5130, 1'b0);
        base_a = {dst_sel, srca_sel, srcb_sel, alu_op, wb_src, fx(), 7'd0};
        apply(16'h51B8, 1'b0);
        base_b = {dst_sel, srca_sel, srcb_sel, alu_op, wb_src, fx(), 7'd0};
        chk("R12 reserved ldr", base_b, base_a);
    endtask

    task automatic t_rz();
        apply(16'h9034, 1'b0);
        chk("R13 cmp reg_we", reg_we, 0);
        chk("R13 cmp flag_we", flag_we, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_nop();
        t_movl();
        t_seth();
        t_str();
        t_ldr();
        t_alu();
        t_cond();
        t_pc();
        t_undef();
        t_reserved();
        t_rz();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule